// File: doc/BRIEF.md
# Serial Link Lane Power-Up Sequencer

This block brings a multi-lane serial transceiver out of its powered-down state in a fixed and timed order. After reset it holds every lane powerdown, every lane reset and every PLL reset asserted, which keeps the link safe. A start request in the idle state asserts all of these controls together and captures the per-lane configuration word. The block then releases the controls one group at a time, with a programmable wait before each step. Lane pair 0/1 comes fully up before pair 2/3 is touched.

Each wait is counted in pulses of a one-microsecond strobe supplied by the surrounding logic. After the last group is released the block waits once more. It then pulses a done flag for one cycle, drops busy and leaves every control deasserted. Start requests that arrive during the sequence have no effect. The analog transceiver and PLL lock detection are outside the block.

Top module: `lane_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, every bit of `pdn_o`, `pll_rst_o` and `lane_rst_o` is 1 (asserted). `busy_o` and `done_o` are 0 and `cfg_o` is 0.
- R2: A `start_i` pulse sampled while `busy_o` is 0 sets every control bit to 1 and raises `busy_o`, both visible in the next cycle.
- R3: Each wait ends on the DELAY_US-th `us_tick_i` pulse (default 15) sampled while `busy_o` is 1. A tick sampled in the same cycle as the accepted start is not counted, and cycles without a tick do not advance the wait.
- R4: The release order is fixed. First `pdn_o[1:0]`, then `pll_rst_o[0]`, then `lane_rst_o[1:0]`, then `pdn_o[3:2]`, then `pll_rst_o[1]`, then `lane_rst_o[3:2]`. Bit i of `pdn_o` and `lane_rst_o` belongs to lane i. Bit 0 of `pll_rst_o` serves lanes 0/1 and bit 1 serves lanes 2/3.
- R5: A release step clears only its own group, in the cycle after the wait that precedes it ends. No control bit rises while `busy_o` stays high.
- R6: One wait after the sixth release, `done_o` is 1 for exactly one cycle. In that same cycle `busy_o` is 0 and every control bit is 0.
- R7: A `start_i` pulse while `busy_o` is 1 is ignored. The outputs do not change and the wait in progress is not restarted.
- R8: `cfg_o` takes the value of `cfg_i` only when a start is accepted. Changes to `cfg_i` at any other time do not reach `cfg_o`.
- R9: In the idle state, with no start request, the outputs hold their values whatever `us_tick_i` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request to run the power-up sequence |
| us_tick_i | input | 1 | One-cycle strobe, once per microsecond |
| cfg_i | input | LANES*CFG_W | Per-lane static configuration, lane 0 in the low bits |
| cfg_o | output | LANES*CFG_W | Configuration captured at start |
| pdn_o | output | LANES | Lane powerdown controls, 1 = powered down |
| pll_rst_o | output | LANES/2 | PLL resets, one per lane pair, 1 = in reset |
| lane_rst_o | output | LANES | Lane resets, 1 = in reset |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of the sequence |

## Verification
A corrupt step index releases the wrong group. That shows at the control outputs in the cycle after the wait expires, as a pair whose reset drops ahead of its PLL or a second pair moving too early. A wait counter that is off by one moves every release one tick early or late, and this appears at the first release, 15 ticks after start. A busy flag that drops too soon either lets a mid-sequence start reassert the controls or loses the done pulse. Either fault shows within one cycle of the offending event.

// File: rtl/lps_pkg.sv
package lps_pkg;

  // Release kinds within one lane pair, in the order they are applied.
  typedef enum logic [1:0] {
    KIND_PWR  = 2'd0,
    KIND_PLL  = 2'd1,
    KIND_LANE = 2'd2
  } step_kind_e;

  localparam int unsigned KINDS_PER_PAIR = 3;

  // Global step number of a release kind for a given lane pair.
  function automatic int unsigned step_of(input int unsigned pair,
                                          input step_kind_e kind);
    return pair * KINDS_PER_PAIR + int'(kind);
  endfunction

endpackage

// File: rtl/lps_delay_cnt.sv
module lps_delay_cnt #(
  parameter int unsigned DELAY_US = 15,
  localparam int unsigned CNT_W   = $clog2(DELAY_US + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_US - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expire_o = run_i & tick_i & (cnt_q == LAST);

  always_comb begin
    cnt_en = clr_i | (run_i & tick_i);
    cnt_d  = cnt_q;
    if (clr_i || expire_o) begin
      cnt_d = '0;
    end else if (run_i && tick_i) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/lps_step_ctrl.sv
module lps_step_ctrl #(
  parameter int unsigned NSTEPS = 6,
  localparam int unsigned STEP_W = $clog2(NSTEPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              expire_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              accept_o,
  output logic              release_o,
  output logic [STEP_W-1:0] step_o
);

  localparam logic [STEP_W-1:0] FINAL = STEP_W'(NSTEPS);

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              last_wait;

  assign accept_o  = start_i & ~busy_q;
  assign last_wait = (step_q == FINAL);
  assign release_o = busy_q & expire_i & ~last_wait;

  always_comb begin
    busy_d = busy_q;
    step_d = step_q;
    done_d = 1'b0;
    if (accept_o) begin
      busy_d = 1'b1;
      step_d = '0;
    end else if (busy_q && expire_i) begin
      if (last_wait) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        step_d = step_q + STEP_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      step_q <= step_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign step_o = step_q;

endmodule

// File: rtl/lps_ctrl_regs.sv
module lps_ctrl_regs
  import lps_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned STEP_W = 3,
  localparam int unsigned PAIRS = LANES / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              assert_all_i,
  input  logic              release_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [LANES-1:0]  pdn_o,
  output logic [PAIRS-1:0]  pll_rst_o,
  output logic [LANES-1:0]  lane_rst_o
);

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam logic [STEP_W-1:0] S_PWR  = STEP_W'(step_of(p, KIND_PWR));
    localparam logic [STEP_W-1:0] S_PLL  = STEP_W'(step_of(p, KIND_PLL));
    localparam logic [STEP_W-1:0] S_LANE = STEP_W'(step_of(p, KIND_LANE));

    logic       clr_pwr, clr_pll, clr_lane;
    logic       upd_pwr, upd_pll, upd_lane;
    logic [1:0] pwr_q, pwr_d;
    logic       pll_q, pll_d;
    logic [1:0] lrst_q, lrst_d;

    always_comb begin
      clr_pwr  = release_i && (step_i == S_PWR);
      clr_pll  = release_i && (step_i == S_PLL);
      clr_lane = release_i && (step_i == S_LANE);
      upd_pwr  = assert_all_i | clr_pwr;
      upd_pll  = assert_all_i | clr_pll;
      upd_lane = assert_all_i | clr_lane;
      pwr_d    = assert_all_i ? 2'b11 : 2'b00;
      pll_d    = assert_all_i;
      lrst_d   = assert_all_i ? 2'b11 : 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pwr_q  <= 2'b11;
        pll_q  <= 1'b1;
        lrst_q <= 2'b11;
      end else begin
        if (upd_pwr)  pwr_q  <= pwr_d;
        if (upd_pll)  pll_q  <= pll_d;
        if (upd_lane) lrst_q <= lrst_d;
      end
    end

    assign pdn_o[2*p +: 2]      = pwr_q;
    assign pll_rst_o[p]         = pll_q;
    assign lane_rst_o[2*p +: 2] = lrst_q;
  end

endmodule

// File: rtl/lane_pwrup_seq.sv
module lane_pwrup_seq #(
  parameter int unsigned LANES    = 4,
  parameter int unsigned CFG_W    = 8,
  parameter int unsigned DELAY_US = 15
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   us_tick_i,
  input  logic [LANES*CFG_W-1:0] cfg_i,
  output logic [LANES*CFG_W-1:0] cfg_o,
  output logic [LANES-1:0]       pdn_o,
  output logic [LANES/2-1:0]     pll_rst_o,
  output logic [LANES-1:0]       lane_rst_o,
  output logic                   busy_o,
  output logic                   done_o
);

  localparam int unsigned PAIRS  = LANES / 2;
  localparam int unsigned NSTEPS = lps_pkg::KINDS_PER_PAIR * PAIRS;
  localparam int unsigned STEP_W = $clog2(NSTEPS + 1);

  logic              accept;
  logic              release_s;
  logic              expire;
  logic [STEP_W-1:0] step;
  logic              busy_s;

  lps_step_ctrl #(.NSTEPS(NSTEPS)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .expire_i  (expire),
    .busy_o    (busy_s),
    .done_o    (done_o),
    .accept_o  (accept),
    .release_o (release_s),
    .step_o    (step)
  );

  lps_delay_cnt #(.DELAY_US(DELAY_US)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (accept),
    .run_i    (busy_s),
    .tick_i   (us_tick_i),
    .expire_o (expire)
  );

  lps_ctrl_regs #(.LANES(LANES), .STEP_W(STEP_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .assert_all_i (accept),
    .release_i    (release_s),
    .step_i       (step),
    .pdn_o        (pdn_o),
    .pll_rst_o    (pll_rst_o),
    .lane_rst_o   (lane_rst_o)
  );

  logic [LANES*CFG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (accept) begin
      cfg_q <= cfg_i;
    end
  end

  assign cfg_o  = cfg_q;
  assign busy_o = busy_s;

endmodule

// File: rtl/lps_seq_checker.sv
module lps_seq_checker #(
  parameter int unsigned LANES = 4,
  parameter int unsigned CFG_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start_i,
  input logic                   us_tick_i,
  input logic [LANES*CFG_W-1:0] cfg_o,
  input logic [LANES-1:0]       pdn_o,
  input logic [LANES/2-1:0]     pll_rst_o,
  input logic [LANES-1:0]       lane_rst_o,
  input logic                   busy_o,
  input logic                   done_o
);

  localparam int unsigned PAIRS = LANES / 2;
  localparam int unsigned NCTRL = 2 * LANES + PAIRS;

  logic [NCTRL-1:0] ctrl;
  assign ctrl = {lane_rst_o, pll_rst_o, pdn_o};

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_all_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && ctrl == '0));

  assert_no_rise_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ((ctrl & ~$past(ctrl)) == '0));

  assert_one_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($countones($past(ctrl) & ~ctrl) <= 2));

  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !us_tick_i) |=> ($stable(ctrl) && busy_o));

  assert_no_tick_no_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !us_tick_i && !done_o) |=> ($stable(ctrl) && !done_o));

  assert_cfg_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(cfg_o));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(ctrl) && $stable(cfg_o) && !busy_o));

  for (genvar p = 0; p < PAIRS; p++) begin : g_order
    assert_pll_after_pwr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_rst_o[p] |-> (pdn_o[2*p +: 2] == 2'b00));

    assert_lane_after_pll_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_rst_o[2*p +: 2] != 2'b11) |-> !pll_rst_o[p]);

    if (p > 0) begin : g_prev
      assert_pair_after_prev_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pdn_o[2*p +: 2] != 2'b11) |-> (lane_rst_o[2*(p-1) +: 2] == 2'b00));
    end
  end

endmodule

bind lane_pwrup_seq lps_seq_checker #(.LANES(LANES), .CFG_W(CFG_W)) u_lps_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .us_tick_i  (us_tick_i),
  .cfg_o      (cfg_o),
  .pdn_o      (pdn_o),
  .pll_rst_o  (pll_rst_o),
  .lane_rst_o (lane_rst_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/test_lane_pwrup_seq.sv
module test_lane_pwrup_seq;

  localparam int unsigned LANES = 4;
  localparam int unsigned CFG_W = 8;
  localparam int unsigned DLY   = 15;
  localparam int unsigned CW    = LANES * CFG_W;

  // Packed view {done, busy, lane_rst[3:0], pll_rst[1:0], pdn[3:0]}
  localparam logic [11:0] ST_ALL  = 12'b01_1111_11_1111;
  localparam logic [11:0] ST_RST  = 12'b00_1111_11_1111;
  localparam logic [11:0] ST_IDLE = 12'b00_0000_00_0000;
  localparam logic [11:0] REL_TBL [7] = '{
    12'b01_1111_11_1100,
    12'b01_1111_10_1100,
    12'b01_1100_10_1100,
    12'b01_1100_10_0000,
    12'b01_1100_00_0000,
    12'b01_0000_00_0000,
    12'b10_0000_00_0000
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic          us_tick_i;
  logic [CW-1:0] cfg_i;
  logic [CW-1:0] cfg_o;
  logic [3:0]    pdn_o;
  logic [1:0]    pll_rst_o;
  logic [3:0]    lane_rst_o;
  logic          busy_o;
  logic          done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  lane_pwrup_seq #(.LANES(LANES), .CFG_W(CFG_W), .DELAY_US(DLY)) i_lane_pwrup_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .us_tick_i  (us_tick_i),
    .cfg_i      (cfg_i),
    .cfg_o      (cfg_o),
    .pdn_o      (pdn_o),
    .pll_rst_o  (pll_rst_o),
    .lane_rst_o (lane_rst_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  function automatic logic [11:0] state_now();
    return {done_o, busy_o, lane_rst_o, pll_rst_o, pdn_o};
  endfunction

  task automatic check_state(input string req, input logic [11:0] exp);
    checks++;
    if (state_now() !== exp) begin
      errors++;
      $display("FAIL %s: state actual %b expected %b", req, state_now(), exp);
    end
  endtask

  task automatic check_cfg(input string req, input logic [CW-1:0] exp);
    checks++;
    if (cfg_o !== exp) begin
      errors++;
      $display("FAIL %s: cfg actual %h expected %h", req, cfg_o, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) us_tick_i = 1'b1;
      @(negedge clk) us_tick_i = 1'b0;
    end
  endtask

  task automatic pulse_start(input logic with_tick);
    @(negedge clk);
    start_i   = 1'b1;
    us_tick_i = with_tick;
    @(negedge clk);
    start_i   = 1'b0;
    us_tick_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: cycles actual %0d expected below 50000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n     = 1'b0;
    start_i   = 1'b0;
    us_tick_i = 1'b0;
    cfg_i     = 32'hA5C3_1E77;
    repeat (3) @(negedge clk);
    check_state("R1 in reset", ST_RST);
    check_cfg("R1 cfg in reset", '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_state("R1 after reset", ST_RST);

    // R9: ticks while idle do nothing
    ticks(DLY + 2);
    check_state("R9 idle ticks after reset", ST_RST);

    // R2: accepted start
    pulse_start(1'b0);
    check_state("R2 start asserts all", ST_ALL);
    check_cfg("R8 cfg captured", 32'hA5C3_1E77);
    cfg_i = 32'h0F0F_5A5A;

    // Table walk: each wait then one release (R3, R4, R5, R6)
    for (int i = 0; i < 7; i++) begin
      logic [11:0] prev;
      prev = (i == 0) ? ST_ALL : REL_TBL[i-1];
      if (i == 1) begin
        repeat (40) @(negedge clk);
        check_state("R3 no tick no advance", prev);
      end
      if (i == 2) begin
        ticks(7);
        pulse_start(1'b0);
        check_state("R7 start while busy ignored", prev);
        ticks(7);
      end else begin
        ticks(DLY - 1);
      end
      check_state("R3 before wait ends", prev);
      ticks(1);
      check_state("R4 R5 R6 release step", REL_TBL[i]);
    end
    check_cfg("R8 cfg held during run", 32'hA5C3_1E77);

    @(negedge clk);
    check_state("R6 done single cycle", ST_IDLE);
    ticks(DLY + 1);
    check_state("R9 idle after done", ST_IDLE);
    check_cfg("R9 cfg idle", 32'hA5C3_1E77);

    // R3: tick coincident with start not counted
    pulse_start(1'b1);
    check_state("R2 restart asserts all", ST_ALL);
    check_cfg("R8 cfg recaptured", 32'h0F0F_5A5A);
    ticks(DLY - 1);
    check_state("R3 start-cycle tick not counted", ST_ALL);
    ticks(1);
    check_state("R3 first release on time", REL_TBL[0]);

    // R1: reset mid sequence returns to safe idle
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check_state("R1 reset mid sequence", ST_RST);
    check_cfg("R1 cfg cleared", '0);
    rst_n = 1'b1;
    @(negedge clk);
    ticks(DLY);
    check_state("R1 R9 stays idle after reset", ST_RST);

    finish_run();
  end

endmodule